// File: doc/BRIEF.md
# Hashed Filter Table Search Engine

The engine keeps a table of packet-filter entries in a power-of-two number of slots and serves insert, replace, lookup and delete commands against it. Each command carries a 32-bit key that has already been built from header fields. The key is folded by a 16-bit shift-register hash into a start slot, and probing then walks the table with an odd stride taken from the key. One slot is probed per clock. Each slot has an occupancy bit, and an occupied slot holds a filter type, three 32-bit match words and a queue number. The probe state of a slot and its stored entry decide whether the walk stops there.

For each of the four filter types the engine records the deepest probe that any successful insert has needed. From that record it drives a padded search limit per type, which the surrounding logic programs into the lookup hardware. Commands enter on a valid/ready channel. `cmd_ready` is high only while the engine is idle, so a held command waits with its fields stable and no command is lost. The response is held on `rsp_valid` with its status, index and depth until the consumer raises `rsp_ready`. The engine takes no new command until that response has been taken.

Top module: `fte_engine`

## Requirements
- R1: The first probe examines slot `H & (N-1)`. H is the 16-bit hash: t = 0x1FFF ^ key[31:16]; t ^= (t>>3) ^ (t>>6); t ^= t>>9; t = t ^ (t<<13) ^ key[15:0]; the same two shift-XOR steps again; all of it kept to 16 bits.
- R2: Probe d+1 examines slot (slot_d + S) & (N-1). The stride S is (2*key - 1) kept to 16 bits.
- R3: After a command is accepted, probe d is taken on the d-th following clock edge. The response appears right after the edge of the final probe, and `rsp_depth` gives the number of probes taken.
- R4: An occupied slot matches a request when its type and all three match words are equal. For transmit types (type bit 1 set) the queue number must also be equal; for receive types it is not compared. Lookup (op 2) returns status OK (0) and the slot of the first match.
- R5: Insert (op 0) or replace (op 1) stops at the first free slot. It stores the entry there, sets the occupancy bit and returns OK (0).
- R6: When an insert (op 0) reaches a matching occupied slot it returns EXISTS (3) and leaves the table unchanged. A replace (op 1) in the same case returns OK and overwrites the stored entry, including the queue number.
- R7: A walk that finds no stopping slot ends after 200 probes with depth 200. The status is FULL (1) for insert or replace and ABSENT (2) for lookup or delete.
- R8: `search_limit` carries one 8-bit field per type, with type t at bits [8t+7:8t]. Each field equals that type's recorded maximum depth plus 1 when type bit 0 is 0 (full match), or plus 3 when bit 0 is 1 (wildcard). The recorded maximum rises to the depth of any successful insert or replace that goes deeper than it.
- R9: Delete (op 3) of a matching entry returns OK and clears the slot's occupancy bit. When that leaves the table empty, every recorded depth returns to 0.
- R10: `cmd_ready` is low from the edge that accepts a command until the edge on which the response is taken. A command offered during that time has no effect. While `rsp_ready` is low, the response fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on this edge if valid |
| cmd_op | input | 2 | 0 insert, 1 replace, 2 lookup, 3 delete |
| cmd_key | input | 32 | Pre-built hash key |
| cmd_type | input | 2 | Filter type: bit 0 wildcard, bit 1 transmit side |
| cmd_w0 | input | 32 | Match word 0 |
| cmd_w1 | input | 32 | Match word 1 |
| cmd_w2 | input | 32 | Match word 2 |
| cmd_qid | input | QW | Queue number |
| rsp_valid | output | 1 | Response held until taken |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_status | output | 2 | 0 OK, 1 FULL, 2 ABSENT, 3 EXISTS |
| rsp_index | output | log2(N) | Slot of the last probe |
| rsp_depth | output | 8 | Probes taken |
| search_limit | output | 32 | Four padded per-type search limits |

## Verification
The assertions assume a reset at start-up and a consumer that eventually raises `rsp_ready`. They do not assume that `cmd_valid` stays low while the engine is busy: the stimulus drives a stray command on purpose while a walk is in progress and expects nothing to change. The bench keeps all command fields stable while `cmd_valid` is high and not yet accepted. It picks keys whose hashes land on the same start slot so that collision walks are exercised. It also fills every slot, which forces the 200-probe cap.

// File: rtl/fte_pkg.sv
package fte_pkg;
  localparam int WORD_W = 32;
  localparam int TYPE_W = 2;
  localparam int NTYPES = 1 << TYPE_W;

  typedef enum logic [1:0] {
    OP_INSERT  = 2'd0,
    OP_REPLACE = 2'd1,
    OP_LOOKUP  = 2'd2,
    OP_DELETE  = 2'd3
  } fte_op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_FULL   = 2'd1,
    ST_ABSENT = 2'd2,
    ST_EXISTS = 2'd3
  } fte_status_e;

  typedef struct packed {
    logic [TYPE_W-1:0] ftype;
    logic [WORD_W-1:0] w2;
    logic [WORD_W-1:0] w1;
    logic [WORD_W-1:0] w0;
  } fte_match_t;
endpackage

// File: rtl/fte_hash.sv
module fte_hash #(
  parameter int IW = 6
) (
  input  logic [31:0]   key,
  output logic [IW-1:0] start_idx,
  output logic [IW-1:0] stride
);
  logic [15:0] s0, s1, s2, s3, s4, s5;
  logic [15:0] step;

  always_comb begin
    s0 = 16'h1fff ^ key[31:16];
    s1 = s0 ^ (s0 >> 3) ^ (s0 >> 6);
    s2 = s1 ^ (s1 >> 9);
    s3 = s2 ^ (s2 << 13) ^ key[15:0];
    s4 = s3 ^ (s3 >> 3) ^ (s3 >> 6);
    s5 = s4 ^ (s4 >> 9);
    step = {key[14:0], 1'b0} - 16'd1;
  end

  assign start_idx = s5[IW-1:0];
  assign stride    = step[IW-1:0];
endmodule

// File: rtl/fte_store.sv
module fte_store
  import fte_pkg::*;
#(
  parameter int N  = 64,
  parameter int QW = 12,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_occ,
  output fte_match_t    rd_match,
  output logic [QW-1:0] rd_qid,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  fte_match_t    wr_match,
  input  logic [QW-1:0] wr_qid,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [IW:0]   used_cnt
);
  logic          occ [N];
  fte_match_t    ent [N];
  logic [QW-1:0] qid [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[i] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(i)) begin
        occ[i] <= 1'b1;
      end else if (clr_en && clr_idx == IW'(i)) begin
        occ[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IW'(i)) begin
        ent[i] <= wr_match;
        qid[i] <= wr_qid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_cnt <= '0;
    end else if (wr_en && !occ[wr_idx]) begin
      used_cnt <= used_cnt + 1'b1;
    end else if (clr_en && occ[clr_idx]) begin
      used_cnt <= used_cnt - 1'b1;
    end
  end

  assign rd_occ   = occ[rd_idx];
  assign rd_match = ent[rd_idx];
  assign rd_qid   = qid[rd_idx];
endmodule

// File: rtl/fte_depth.sv
module fte_depth
  import fte_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [TYPE_W-1:0]    upd_type,
  input  logic [DW-1:0]        upd_depth,
  input  logic                 clr_all,
  output logic [NTYPES*DW-1:0] limits
);
  for (genvar t = 0; t < NTYPES; t++) begin : g_type
    localparam logic [DW-1:0] PAD = (t % 2 == 1) ? DW'(3) : DW'(1);
    logic [DW-1:0] rec;

    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) begin
        rec <= '0;
      end else if (upd_en && upd_type == TYPE_W'(t) && upd_depth > rec) begin
        rec <= upd_depth;
      end
    end

    assign limits[t*DW +: DW] = rec + PAD;
  end
endmodule

// File: rtl/fte_engine.sv
module fte_engine
  import fte_pkg::*;
#(
  parameter int N          = 64,
  parameter int QW         = 12,
  parameter int MAX_PROBES = 200,
  localparam int IW = $clog2(N),
  localparam int DW = $clog2(MAX_PROBES + 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [31:0]          cmd_key,
  input  logic [1:0]           cmd_type,
  input  logic [31:0]          cmd_w0,
  input  logic [31:0]          cmd_w1,
  input  logic [31:0]          cmd_w2,
  input  logic [QW-1:0]        cmd_qid,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [1:0]           rsp_status,
  output logic [IW-1:0]        rsp_index,
  output logic [DW-1:0]        rsp_depth,
  output logic [NTYPES*DW-1:0] search_limit
);
  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_DONE} state_e;

  state_e        state;
  fte_op_e       r_op;
  fte_match_t    r_match;
  logic [QW-1:0] r_qid;
  logic [IW-1:0] r_stride, idx, h_start, h_stride;
  logic [DW-1:0] depth;

  logic          rd_occ;
  fte_match_t    rd_match;
  logic [QW-1:0] rd_qid;
  logic [IW:0]   used_cnt;
  logic          is_ins, same, hit, capped, finish;
  logic          wr_en, clr_en;
  fte_status_e   fin_status;

  fte_hash #(.IW(IW)) u_hash (
    .key(cmd_key), .start_idx(h_start), .stride(h_stride)
  );

  fte_store #(.N(N), .QW(QW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx),
    .rd_occ(rd_occ), .rd_match(rd_match), .rd_qid(rd_qid),
    .wr_en(wr_en), .wr_idx(idx), .wr_match(r_match), .wr_qid(r_qid),
    .clr_en(clr_en), .clr_idx(idx), .used_cnt(used_cnt)
  );

  fte_depth #(.DW(DW)) u_depth (
    .clk(clk), .rst_n(rst_n), .upd_en(wr_en), .upd_type(r_match.ftype),
    .upd_depth(depth), .clr_all(clr_en && used_cnt == 1),
    .limits(search_limit)
  );

  always_comb begin
    is_ins = (r_op == OP_INSERT) || (r_op == OP_REPLACE);
    same   = (rd_match == r_match) && (!r_match.ftype[1] || rd_qid == r_qid);
    hit    = rd_occ ? same : is_ins;
    capped = (depth == DW'(MAX_PROBES));
    finish = (state == S_PROBE) && (hit || capped);
    wr_en  = (state == S_PROBE) && hit && is_ins && (!rd_occ || r_op == OP_REPLACE);
    clr_en = (state == S_PROBE) && hit && (r_op == OP_DELETE);
    if (hit) begin
      fin_status = (is_ins && rd_occ && r_op == OP_INSERT) ? ST_EXISTS : ST_OK;
    end else begin
      fin_status = is_ins ? ST_FULL : ST_ABSENT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      r_op       <= OP_LOOKUP;
      r_match    <= '0;
      r_qid      <= '0;
      r_stride   <= '0;
      idx        <= '0;
      depth      <= '0;
      rsp_status <= '0;
      rsp_index  <= '0;
      rsp_depth  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          r_op     <= fte_op_e'(cmd_op);
          r_match  <= '{ftype: cmd_type, w2: cmd_w2, w1: cmd_w1, w0: cmd_w0};
          r_qid    <= cmd_qid;
          r_stride <= h_stride;
          idx      <= h_start;
          depth    <= DW'(1);
          state    <= S_PROBE;
        end
        S_PROBE: if (finish) begin
          rsp_status <= fin_status;
          rsp_index  <= idx;
          rsp_depth  <= depth;
          state      <= S_DONE;
        end else begin
          idx   <= idx + r_stride;
          depth <= depth + 1'b1;
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_DONE);
endmodule

// File: rtl/fte_engine_chk.sv
module fte_engine_chk #(
  parameter int IW = 6,
  parameter int DW = 8,
  parameter int MAX_PROBES = 200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_status,
  input logic [IW-1:0] rsp_index,
  input logic [DW-1:0] rsp_depth,
  input logic [4*DW-1:0] search_limit
);
  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status)
      && $stable(rsp_index) && $stable(rsp_depth));

  p_accept_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready && !rsp_valid);

  p_depth_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_depth >= 1 && rsp_depth <= DW'(MAX_PROBES));

  p_full_at_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status == 2'd1 || rsp_status == 2'd2)
      |-> rsp_depth == DW'(MAX_PROBES));

  for (genvar t = 0; t < 4; t++) begin : g_lim
    p_limit_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      search_limit[t*DW +: DW] >= ((t % 2 == 1) ? DW'(3) : DW'(1)));
  end
endmodule

bind fte_engine fte_engine_chk #(.IW(IW), .DW(DW), .MAX_PROBES(MAX_PROBES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
  .rsp_index(rsp_index), .rsp_depth(rsp_depth), .search_limit(search_limit)
);

// File: tb/fte_engine_bench.sv
module fte_engine_bench;
  localparam int N = 64;
  localparam int QW = 12;
  localparam int MAXP = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_key = '0;
  logic [1:0] cmd_type = '0;
  logic [31:0] cmd_w0 = '0, cmd_w1 = '0, cmd_w2 = '0;
  logic [QW-1:0] cmd_qid = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [1:0] rsp_status;
  logic [5:0] rsp_index;
  logic [7:0] rsp_depth;
  logic [31:0] search_limit;

  always #2 clk = ~clk;

  fte_engine u_fte_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_type(cmd_type),
    .cmd_w0(cmd_w0), .cmd_w1(cmd_w1), .cmd_w2(cmd_w2), .cmd_qid(cmd_qid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_index(rsp_index), .rsp_depth(rsp_depth), .search_limit(search_limit)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned bhash(input int unsigned k);
    int unsigned t;
    t = (32'h1fff ^ (k >> 16)) & 32'hffff;
    t = t ^ (t >> 3) ^ (t >> 6);
    t = (t ^ (t >> 9)) & 32'hffff;
    t = (t ^ (t << 13) ^ (k & 32'hffff)) & 32'hffff;
    t = t ^ (t >> 3) ^ (t >> 6);
    t = (t ^ (t >> 9)) & 32'hffff;
    return t;
  endfunction

  // behavioural reference model
  bit m_occ [N];
  int unsigned m_ty [N], m_a [N], m_b [N], m_c [N], m_q [N];
  int m_rec [4];
  int m_used, m_cnt;
  bit m_rsp;
  int e_status, e_index, e_depth, e_op;
  int p_ty, p_a, p_b, p_c, p_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_occ[i]) m_occ[i] = 0;
      foreach (m_rec[i]) m_rec[i] = 0;
      m_used = 0; m_cnt = 0; m_rsp = 0;
    end else begin
      bit idle;
      idle = (m_cnt == 0) && !m_rsp;
      if (m_rsp && rsp_ready) m_rsp = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_rsp = 1;
          if (e_status == 0 && e_op <= 1) begin
            if (!m_occ[e_index]) m_used++;
            m_occ[e_index] = 1;
            m_ty[e_index] = p_ty; m_a[e_index] = p_a; m_b[e_index] = p_b;
            m_c[e_index] = p_c; m_q[e_index] = p_q;
            if (e_depth > m_rec[p_ty]) m_rec[p_ty] = e_depth;
          end else if (e_status == 0 && e_op == 3) begin
            m_occ[e_index] = 0;
            m_used--;
            if (m_used == 0) foreach (m_rec[i]) m_rec[i] = 0;
          end
        end
      end
      if (idle && cmd_valid) begin
        int unsigned ix, st;
        bit ins, done, eq;
        e_op = cmd_op; p_ty = cmd_type; p_a = cmd_w0; p_b = cmd_w1;
        p_c = cmd_w2; p_q = cmd_qid;
        ins = (e_op <= 1);
        ix = bhash(cmd_key) % N;
        st = ((cmd_key * 2) - 1) & 32'hffff;
        done = 0;
        for (int d = 1; d <= MAXP && !done; d++) begin
          eq = m_occ[ix] && m_ty[ix] == p_ty && m_a[ix] == p_a && m_b[ix] == p_b
               && m_c[ix] == p_c && (p_ty < 2 || m_q[ix] == p_q);
          e_index = ix; e_depth = d;
          if (m_occ[ix] ? eq : ins) begin
            done = 1;
            e_status = (ins && m_occ[ix] && e_op == 0) ? 3 : 0;
          end else if (d == MAXP) begin
            done = 1;
            e_status = ins ? 1 : 2;
          end else begin
            ix = (ix + st) % N;
          end
        end
        m_cnt = e_depth;
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_ready == ((m_cnt == 0) && !m_rsp), "R10", "cmd_ready",
          cmd_ready, (m_cnt == 0) && !m_rsp);
      chk(rsp_valid == m_rsp, "R3", "rsp_valid timing", rsp_valid, m_rsp);
      for (int t = 0; t < 4; t++)
        chk(search_limit[t*8 +: 8] == m_rec[t] + ((t % 2) ? 3 : 1), "R8",
            $sformatf("limit type %0d", t), search_limit[t*8 +: 8],
            m_rec[t] + ((t % 2) ? 3 : 1));
      if (m_rsp && rsp_valid) begin
        string rq;
        if (e_status == 3) rq = "R6";
        else if (e_status != 0) rq = "R7";
        else if (e_op == 3) rq = "R9";
        else if (e_op == 2) rq = "R4";
        else if (e_op == 1) rq = "R6";
        else rq = "R5";
        chk(rsp_status == e_status, rq, "status", rsp_status, e_status);
        chk(rsp_index == e_index, (e_depth > 1) ? "R2" : "R1", "index",
            rsp_index, e_index);
        chk(rsp_depth == e_depth, "R3", "depth", rsp_depth, e_depth);
      end
    end
  end

  task automatic run(input int op, input int unsigned key, input int ty,
                     input int unsigned w0, input int unsigned w1,
                     input int unsigned w2, input int q, input bit stray);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_key = key; cmd_type = 2'(ty);
    cmd_w0 = w0; cmd_w1 = w1; cmd_w2 = w2; cmd_qid = QW'(q);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    if (stray) begin
      // R10: a command offered while busy must be ignored
      cmd_op = 2'd3; cmd_key = key ^ 32'h55;
    end else begin
      cmd_valid = 0;
    end
    while (!rsp_valid) @(negedge clk);
    cmd_valid = 0;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
  endtask

  int unsigned coll [3];
  int watchdog = 0;

  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", watchdog, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // reset state: R10 ready, R8 padded limits
    chk(cmd_ready == 1, "R10", "ready after reset", cmd_ready, 1);
    chk(rsp_valid == 0, "R10", "no response after reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // find three keys sharing a start slot for collision walks (R2)
    n = 0;
    for (int unsigned k = 32'h100; n < 3; k++)
      if (bhash(k) % N == bhash(32'h100) % N) begin coll[n] = k; n++; end

    run(0, coll[0], 0, 1, 2, 3, 7, 0);        // R5 insert
    run(0, coll[0], 0, 1, 2, 3, 7, 0);        // R6 exists
    run(1, coll[0], 0, 1, 2, 3, 9, 0);        // R6 replace
    run(0, coll[1], 0, 4, 5, 6, 1, 0);        // R2 collision, depth 2
    run(0, coll[2], 1, 4, 5, 6, 1, 1);        // R8 wildcard + R10 stray
    run(2, coll[1], 0, 4, 5, 6, 99, 0);       // R4 rx ignores queue
    run(2, coll[1], 0, 4, 5, 7, 1, 0);        // R7 absent
    run(0, 32'h777, 2, 8, 8, 8, 5, 0);        // transmit type insert
    run(2, 32'h777, 2, 8, 8, 8, 6, 0);        // R4 tx queue differs -> absent
    run(2, 32'h777, 2, 8, 8, 8, 5, 0);        // R4 tx match
    rsp_ready = 0;                            // R10 hold
    fork
      run(2, 32'h777, 2, 8, 8, 8, 5, 0);
      begin repeat (8) @(negedge clk); rsp_ready = 1; end
    join
    // R9 delete all, depths reset
    run(3, coll[0], 0, 1, 2, 3, 0, 0);
    run(3, coll[1], 0, 4, 5, 6, 0, 0);
    run(3, coll[2], 1, 4, 5, 6, 0, 0);
    run(3, 32'h777, 2, 8, 8, 8, 5, 0);
    run(3, 32'h777, 2, 8, 8, 8, 5, 0);        // R7 delete absent
    // fill table, then R7 full
    for (int i = 0; i < N; i++) run(0, 32'h9000 + i * 37, 1, i, 0, 0, 0, 0);
    run(0, 32'h4242, 1, 999, 0, 0, 0, 0);
    run(1, 32'h4243, 3, 1, 1, 1, 1, 0);
    run(2, 32'h4244, 0, 5, 5, 5, 0, 0);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule